// File: doc/BRIEF.md
# SDRAM Auto-Refresh Gate

This block sits between a periodic refresh timer and the SDRAM command sequencer. It decides when a pending auto-refresh may run without cutting into bus activity. The timer's compare-match pulse records a single outstanding refresh request. The gate then waits until no hold-off condition is present before it fires a one-clock refresh strobe. The hold-off conditions are:

- a running bus cycle;
- the later beats of an access split across a narrow data bus;
- a 32-byte line fill or write-back;
- the window between the read and the write of an atomic test-and-set;
- the window between the two halves of a dual-address DMA move;
- the bus being granted away to another master.

Requests do not queue. A pulse that arrives while a request is still waiting replaces it, and a saturating counter records each replaced request. While a request waits, the active-low bus acknowledge is forced high. An external master watching it then knows it must hand the bus back. When the bus is idle and owned, a pending refresh takes priority over a new bus cycle request arriving in the same clock.

Top module: `sdram_refresh_gate`

## Requirements
- R1: After reset, `refresh_go_o` is 0, `drop_cnt_o` is 0, and no request is pending. With `bus_released_i` low, `bus_ack_n_o` is 1.
- R2: A `tick_i` pulse sampled at clock edge k, with every hold-off input low, produces `refresh_go_o` = 1 for exactly one clock. The strobe starts after edge k+1, and the request is cleared at that same edge.
- R3: While `cyc_active_i` is high, no strobe is issued. The strobe appears after the first edge at which `cyc_active_i` is sampled low.
- R4: Each of `split_busy_i`, `line_xfer_i`, `rmw_window_i` and `dma_dual_i` defers a pending refresh in the same way as R3.
- R5: While `bus_released_i` is high, a pending refresh waits. It issues after the first edge at which the input is sampled low.
- R6: `bus_ack_n_o` is 1 whenever a request is pending or the bus is owned. It is 0 only when `bus_released_i` is high and nothing is pending.
- R7: A `tick_i` sampled while a request is pending and not being issued leaves exactly one request outstanding and adds 1 to `drop_cnt_o`. The hold-off then yields only one strobe.
- R8: `drop_cnt_o` saturates at 2^DROP_W-1, which is 15 for the default DROP_W = 4.
- R9: `cyc_grant_o` = 1 only when `cyc_req_i` is high, `bus_released_i` is low, no request is pending and no strobe is active. A pending refresh therefore wins over a same-clock cycle request.
- R10: A `tick_i` sampled at the same edge at which a strobe is issued becomes a new pending request and is not counted as dropped. That request issues no earlier than one clock after the strobe ends, so two strobes are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Compare-match pulse from the refresh interval timer |
| cyc_active_i | input | 1 | A bus cycle is in progress |
| split_busy_i | input | 1 | A split narrow-bus access sequence is in progress |
| line_xfer_i | input | 1 | A 32-byte line transfer is in progress |
| rmw_window_i | input | 1 | Between the read and the write of an atomic test-and-set |
| dma_dual_i | input | 1 | Between the halves of a dual-address DMA transfer |
| bus_released_i | input | 1 | The bus is currently granted to another master |
| cyc_req_i | input | 1 | A new bus cycle requests to start |
| refresh_go_o | output | 1 | One-clock auto-refresh command strobe |
| cyc_grant_o | output | 1 | The new bus cycle may start this clock |
| bus_ack_n_o | output | 1 | Bus acknowledge, active low; high while refresh is pending |
| drop_cnt_o | output | DROP_W | Saturating count of replaced refresh requests |

## Verification
The bench holds each of the six hold-off sources high across several clocks and confirms that no strobe leaks out. It then checks that exactly one strobe follows the release. A gate that ignored one source would refresh in the middle of a line fill or an atomic pair.

Repeated pulses under hold-off must give a single strobe and an exact drop count, which must pin at 15. A design that queued requests would emit a burst of strobes, and one without saturation would wrap the count to a small value.

A pulse that coincides with an issue must not count as a drop and must not give adjacent strobes. The acknowledge and grant outputs are checked around a pending request, which exposes an inverted acknowledge or a cycle grant that beats the refresh.

// File: rtl/sdram_refresh_pkg.sv
package sdram_refresh_pkg;

    localparam int unsigned HOLD_SRCS = 6;

    typedef enum logic [2:0] {
        HS_CYCLE   = 3'd0,
        HS_SPLIT   = 3'd1,
        HS_LINE    = 3'd2,
        HS_RMW     = 3'd3,
        HS_DMA     = 3'd4,
        HS_RELEASE = 3'd5
    } hold_src_e;

endpackage

// File: rtl/refresh_holdoff.sv
module refresh_holdoff #(
    parameter int unsigned N_SRC = 6
) (
    input  logic [N_SRC-1:0] src_i,
    output logic             hold_o
);

    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < N_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | src_i[g];
    end

    assign hold_o = chain[N_SRC];

endmodule

// File: rtl/refresh_req_track.sv
module refresh_req_track #(
    parameter int unsigned DROP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_i,
    output logic              pending_o,
    output logic              go_o,
    output logic [DROP_W-1:0] drop_o
);

    localparam logic [DROP_W-1:0] DROP_MAX = {DROP_W{1'b1}};

    typedef struct packed {
        logic              pending;
        logic              go;
        logic [DROP_W-1:0] drop;
    } trk_t;

    trk_t st_d, st_q;
    logic issue;

    always_comb begin
        st_d  = st_q;
        issue = st_q.pending & ~hold_i & ~st_q.go;
        st_d.go = issue;
        if (tick_i) begin
            st_d.pending = 1'b1;
            if (st_q.pending && !issue && st_q.drop != DROP_MAX) begin
                st_d.drop = st_q.drop + 1'b1;
            end
        end else if (issue) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pending;
    assign go_o      = st_q.go;
    assign drop_o    = st_q.drop;

    // R2 / R10: a strobe never lasts more than one clock
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> !go_o);

    // R3 / R4 / R5: hold-off sampled high blocks the next strobe
    a_r3_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !go_o);

    // R7: an overwritten request bumps the counter by one
    a_r7_drop_count: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && pending_o && (hold_i || go_o) && drop_o != DROP_MAX)
        |=> drop_o == $past(drop_o) + 1'b1);

    // R8: the counter never wraps
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_o == DROP_MAX) |=> drop_o == DROP_MAX);

    // R2: a strobe only follows a request that was pending
    a_r2_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_o |=> !go_o);

endmodule

// File: rtl/sdram_refresh_gate.sv
module sdram_refresh_gate
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned DROP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cyc_active_i,
    input  logic              split_busy_i,
    input  logic              line_xfer_i,
    input  logic              rmw_window_i,
    input  logic              dma_dual_i,
    input  logic              bus_released_i,
    input  logic              cyc_req_i,
    output logic              refresh_go_o,
    output logic              cyc_grant_o,
    output logic              bus_ack_n_o,
    output logic [DROP_W-1:0] drop_cnt_o
);

    logic [HOLD_SRCS-1:0] hold_src;
    logic                 hold_any;
    logic                 pending;

    always_comb begin
        hold_src             = '0;
        hold_src[HS_CYCLE]   = cyc_active_i;
        hold_src[HS_SPLIT]   = split_busy_i;
        hold_src[HS_LINE]    = line_xfer_i;
        hold_src[HS_RMW]     = rmw_window_i;
        hold_src[HS_DMA]     = dma_dual_i;
        hold_src[HS_RELEASE] = bus_released_i;
    end

    refresh_holdoff #(.N_SRC(HOLD_SRCS)) holdoff_i (
        .src_i  (hold_src),
        .hold_o (hold_any)
    );

    refresh_req_track #(.DROP_W(DROP_W)) track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .hold_i    (hold_any),
        .pending_o (pending),
        .go_o      (refresh_go_o),
        .drop_o    (drop_cnt_o)
    );

    assign bus_ack_n_o = pending | ~bus_released_i;
    assign cyc_grant_o = cyc_req_i & ~bus_released_i & ~pending & ~refresh_go_o;

    // R6: a waiting refresh keeps the acknowledge negated
    a_r6_ack_negated: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> bus_ack_n_o);

    // R9: a pending refresh beats a new cycle request
    a_r9_refresh_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (pending || refresh_go_o) |-> !cyc_grant_o);

    // R5: no strobe follows a clock with the bus granted away
    a_r5_released_waits: assert property (@(posedge clk) disable iff (!rst_n)
        bus_released_i |=> !refresh_go_o);

endmodule

// File: tb/sdram_refresh_gate_tb_top.sv
module sdram_refresh_gate_tb_top;

    localparam int unsigned DW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [5:0] hold_v = '0;
    logic cyc_req = 1'b0;
    logic go, grant, ack_n;
    logic [DW-1:0] drops;

    int n_chk = 0;
    int n_bad = 0;
    int exp_drops = 0;

    always #2 clk = ~clk;

    sdram_refresh_gate #(.DROP_W(DW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .cyc_active_i   (hold_v[0]),
        .split_busy_i   (hold_v[1]),
        .line_xfer_i    (hold_v[2]),
        .rmw_window_i   (hold_v[3]),
        .dma_dual_i     (hold_v[4]),
        .bus_released_i (hold_v[5]),
        .cyc_req_i      (cyc_req),
        .refresh_go_o   (go),
        .cyc_grant_o    (grant),
        .bus_ack_n_o    (ack_n),
        .drop_cnt_o     (drops)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 go", go, 0);
        chk("R1 drops", drops, 0);
        chk("R1 ack_n", ack_n, 1);
    endtask

    task automatic t_basic();
        pulse_tick();
        chk("R2 no strobe yet", go, 0);
        step();
        chk("R2 strobe", go, 1);
        step();
        chk("R2 strobe one clock", go, 0);
        step();
        chk("R2 no repeat", go, 0);
    endtask

    task automatic t_hold(input int idx, input string req);
        hold_v[idx] = 1'b1;
        pulse_tick();
        for (int i = 0; i < 4; i++) begin
            chk(req, go, 0);
            step();
        end
        hold_v[idx] = 1'b0;
        chk(req, go, 0);
        step();
        chk(req, go, 1);
        step();
        chk(req, go, 0);
    endtask

    task automatic t_ack();
        hold_v[5] = 1'b1;
        #1;
        chk("R6 ack low when released", ack_n, 0);
        pulse_tick();
        chk("R6 ack high while pending", ack_n, 1);
        step();
        chk("R5 waits while released", go, 0);
        hold_v[5] = 1'b0;
        step();
        chk("R5 strobe after reacquire", go, 1);
        hold_v[5] = 1'b1;
        #1;
        chk("R6 ack low after refresh", ack_n, 0);
        hold_v[5] = 1'b0;
        step();
    endtask

    task automatic t_drop();
        int strobes = 0;
        hold_v[0] = 1'b1;
        pulse_tick();
        pulse_tick();
        pulse_tick();
        exp_drops += 2;
        chk("R7 two drops", drops, exp_drops);
        hold_v[0] = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            if (go) strobes++;
        end
        chk("R7 single strobe", strobes, 1);
        chk("R7 count kept", drops, exp_drops);
    endtask

    task automatic t_coincide();
        pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
        chk("R10 first strobe", go, 1);
        chk("R10 not a drop", drops, exp_drops);
        step();
        chk("R10 gap", go, 0);
        step();
        chk("R10 second strobe", go, 1);
        step();
    endtask

    task automatic t_prio();
        cyc_req = 1'b1;
        #1;
        chk("R9 grant idle", grant, 1);
        pulse_tick();
        chk("R9 refresh wins", grant, 0);
        step();
        chk("R9 no grant during strobe", grant, 0);
        step();
        chk("R9 grant returns", grant, 1);
        hold_v[5] = 1'b1;
        #1;
        chk("R9 no grant when released", grant, 0);
        hold_v[5] = 1'b0;
        cyc_req = 1'b0;
        step();
    endtask

    task automatic t_saturate();
        hold_v[2] = 1'b1;
        pulse_tick();
        for (int i = 0; i < 20; i++) pulse_tick();
        chk("R8 saturated", drops, 15);
        hold_v[2] = 1'b0;
        step();
        step();
        step();
        chk("R8 held", drops, 15);
    endtask

    initial begin
        #20000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_hold(0, "R3 cycle active");
        t_hold(1, "R4 split");
        t_hold(2, "R4 line xfer");
        t_hold(3, "R4 rmw");
        t_hold(4, "R4 dma dual");
        t_hold(5, "R5 released");
        t_ack();
        t_drop();
        t_coincide();
        t_prio();
        t_saturate();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule